// File: doc/BRIEF.md
# Radix-2 SRT Carry-Save Division Core

This block runs the digit recurrence of a radix-2 SRT divider on two pre-normalized two's-complement operands. It produces one signed quotient digit from {-1, 0, +1} per step. Between steps the partial remainder stays in carry-save form, as a sum vector and a carry vector. No step waits for a full-width carry chain. Each step adds only the top four bits of the doubled sum and carry vectors to get a coarse estimate. It picks the digit from that estimate and folds plus or minus the divisor, or nothing, into the vectors with a 3:2 compressor.

Operand values are read as fractions in [-1, 1), with the sign bit weighted -1. The divisor must be normalized, so its two top bits differ. The dividend may hold any value. Internally the remainder carries three integer bits and OP_W fraction bits. The recurrence starts from half the dividend.

The result is not converted. The caller gets the positive-digit vector, the negative-digit vector and the final sum and carry vectors. A later stage can then form the binary quotient and correct the remainder. One parameter sets the latency. Several steps are chained per cycle when the latency is short, and the core is purely combinational when the latency is zero.

Top module: `srt_div_core`

## Requirements
- R1: The quotient has NDIG = OP_W + 1 + EXTRA_Q digits. Bit i of `q_pos_o` and bit i of `q_neg_o` together encode one digit: +1 when only the positive bit is set, -1 when only the negative bit is set, 0 when neither is set. Both bits are never set together. Bit NDIG-1 holds the first digit produced.
- R2: At ready, let R be the signed RW-bit value (RW = OP_W + 3) of `rem_sum_o + rem_carry_o` taken modulo 2^RW. Let P and N be the digit vectors read as unsigned integers, and x and d the operand integers. Then R = 2^NDIG * x - (P - N) * 2 * d holds.
- R3: At ready, |R| <= 2 * |d|.
- R4: The first digit depends on the dividend x. If x >= 0, the first digit has the sign of the divisor. If -2^(OP_W-2) <= x < 0, the first digit is 0. If x < -2^(OP_W-2), the first digit has the sign opposite to the divisor.
- R5: With LATENCY >= 1, a start sampled in cycle c makes `ready_o` high for exactly cycle c + LATENCY. This holds for every LATENCY, including values below and above NDIG.
- R6: A start that arrives while a division is in flight is ignored. It produces no extra ready, and it does not change the running result.
- R7: While reset is held, `ready_o` is low and every digit and remainder output is zero (LATENCY >= 1).
- R8: With LATENCY >= 1, the operands are captured in the cycle start is accepted. Later changes on the operand inputs have no effect on the result.
- R9: With LATENCY = 0, the core is combinational. `ready_o` follows `start_i` in the same cycle, and the outputs already satisfy R2 to R4 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle start strobe |
| dividend_i | input | OP_W | Dividend, two's complement |
| divisor_i | input | OP_W | Normalized divisor, two's complement |
| ready_o | output | 1 | One-cycle completion pulse |
| q_pos_o | output | NDIG | Positive-digit vector, first digit at MSB |
| q_neg_o | output | NDIG | Negative-digit vector, first digit at MSB |
| rem_sum_o | output | OP_W+3 | Final remainder, sum vector |
| rem_carry_o | output | OP_W+3 | Final remainder, carry vector |

## Verification
The bench builds four copies of the core:
- OP_W=8 with LATENCY equal to the nine-digit count, which gives one digit per cycle.
- OP_W=8 with two extra fraction digits and LATENCY=4. Three steps are chained per cycle, and the final cycle gates off one step.
- OP_W=6 with LATENCY=0, the fully combinational variant.
- OP_W=10 with one extra digit and LATENCY=15. Here idle cycles follow the last digit.

Together these reach the per-cycle gating at both ends of the latency range and the extreme operands: the most negative dividend, a divisor of -1, a zero dividend, and dividends on the -1/2 selection boundary. Starts are also injected during a running division.

// File: rtl/srt_pkg.sv
package srt_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ctrl_state_e;

  // steps chained per clock cycle for a given digit count and latency
  function automatic int steps_per_cycle(int ndig, int lat);
    return (lat == 0) ? ndig : (ndig + lat - 1) / lat;
  endfunction

endpackage

// File: rtl/srt_step.sv
module srt_step #(
  parameter int RW   = 11,
  parameter int NDIG = 9
) (
  input  logic            en_i,
  input  logic [RW-1:0]   sum_i,
  input  logic [RW-1:0]   carry_i,
  input  logic [RW-1:0]   dv_i,
  input  logic [NDIG-1:0] qp_i,
  input  logic [NDIG-1:0] qn_i,
  output logic [RW-1:0]   sum_o,
  output logic [RW-1:0]   carry_o,
  output logic [NDIG-1:0] qp_o,
  output logic [NDIG-1:0] qn_o
);

  logic [RW-1:0] sum2, car2, addend, maj, s_new, c_new;
  logic [3:0]    est;
  logic          nonneg, zero_sel, dneg, dig_p, dig_n;

  assign sum2 = {sum_i[RW-2:0], 1'b0};
  assign car2 = {carry_i[RW-2:0], 1'b0};

  // estimate of 2r truncated to half units: weights -4, 2, 1, 1/2
  assign est      = sum2[RW-1:RW-4] + car2[RW-1:RW-4];
  assign nonneg   = ~est[3];
  assign zero_sel = (est == 4'hF);
  assign dneg     = dv_i[RW-1];

  assign dig_p = ~zero_sel & (nonneg ^ dneg);
  assign dig_n = ~zero_sel & ~(nonneg ^ dneg);

  // r' = 2r - q*d ; subtraction uses ~d with +1 injected at carry LSB
  always_comb begin
    if (dig_p)      addend = ~dv_i;
    else if (dig_n) addend = dv_i;
    else            addend = '0;
  end

  assign maj   = (sum2 & car2) | (sum2 & addend) | (car2 & addend);
  assign s_new = sum2 ^ car2 ^ addend;
  assign c_new = {maj[RW-2:0], dig_p};

  assign sum_o   = en_i ? s_new : sum_i;
  assign carry_o = en_i ? c_new : carry_i;
  assign qp_o    = en_i ? {qp_i[NDIG-2:0], dig_p} : qp_i;
  assign qn_o    = en_i ? {qn_i[NDIG-2:0], dig_n} : qn_i;

endmodule

// File: rtl/srt_ctrl.sv
module srt_ctrl
  import srt_pkg::*;
#(
  parameter int LATENCY = 9,
  parameter int STEPS   = 1,
  parameter int BASE_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              load_o,
  output logic              advance_o,
  output logic              busy_o,
  output logic [BASE_W-1:0] base_o,
  output logic              ready_o
);

  localparam int CW = $clog2(LATENCY + 1);

  ctrl_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic          ready_q;

  assign load_o    = start_i && (state_q == ST_IDLE);
  assign busy_o    = (state_q == ST_RUN);
  assign advance_o = load_o || busy_o;
  assign base_o    = load_o ? '0 : BASE_W'(cnt_q) * BASE_W'(STEPS);
  assign ready_o   = ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      if (load_o) begin
        if (LATENCY == 1) begin
          ready_q <= 1'b1;
        end else begin
          state_q <= ST_RUN;
          cnt_q   <= CW'(1);
        end
      end else if (busy_o) begin
        if (cnt_q == CW'(LATENCY - 1)) begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
          ready_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/srt_div_core.sv
module srt_div_core
  import srt_pkg::*;
#(
  parameter int OP_W    = 8,
  parameter int EXTRA_Q = 0,
  parameter int LATENCY = OP_W + 1 + EXTRA_Q
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [OP_W-1:0]           dividend_i,
  input  logic [OP_W-1:0]           divisor_i,
  output logic                      ready_o,
  output logic [OP_W+EXTRA_Q:0]     q_pos_o,
  output logic [OP_W+EXTRA_Q:0]     q_neg_o,
  output logic [OP_W+2:0]           rem_sum_o,
  output logic [OP_W+2:0]           rem_carry_o
);

  localparam int NDIG   = OP_W + 1 + EXTRA_Q;
  localparam int RW     = OP_W + 3;
  localparam int STEPS  = steps_per_cycle(NDIG, LATENCY);
  localparam int BASE_W = $clog2(LATENCY * STEPS + NDIG + 1) + 1;

  logic [RW-1:0]   x_init, dv_in, dv_cur, dv_act;
  logic            busy;
  logic [STEPS-1:0] stage_en;

  logic [RW-1:0]   ch_sum [STEPS+1];
  logic [RW-1:0]   ch_car [STEPS+1];
  logic [NDIG-1:0] ch_qp  [STEPS+1];
  logic [NDIG-1:0] ch_qn  [STEPS+1];

  // r0 = x/2 : dividend placed with OP_W fraction bits, three integer bits
  assign x_init = {{3{dividend_i[OP_W-1]}}, dividend_i};
  assign dv_in  = {{2{divisor_i[OP_W-1]}}, divisor_i, 1'b0};

  for (genvar s = 0; s < STEPS; s++) begin : g_stage
    srt_step #(.RW(RW), .NDIG(NDIG)) i_step (
      .en_i    (stage_en[s]),
      .sum_i   (ch_sum[s]),
      .carry_i (ch_car[s]),
      .dv_i    (dv_cur),
      .qp_i    (ch_qp[s]),
      .qn_i    (ch_qn[s]),
      .sum_o   (ch_sum[s+1]),
      .carry_o (ch_car[s+1]),
      .qp_o    (ch_qp[s+1]),
      .qn_o    (ch_qn[s+1])
    );
  end

  if (LATENCY == 0) begin : g_comb
    assign ch_sum[0]   = x_init;
    assign ch_car[0]   = '0;
    assign ch_qp[0]    = '0;
    assign ch_qn[0]    = '0;
    assign dv_cur      = dv_in;
    assign dv_act      = dv_in;
    assign busy        = 1'b0;
    assign stage_en    = '1;
    assign ready_o     = start_i;
    assign q_pos_o     = ch_qp[STEPS];
    assign q_neg_o     = ch_qn[STEPS];
    assign rem_sum_o   = ch_sum[STEPS];
    assign rem_carry_o = ch_car[STEPS];
  end else begin : g_seq
    logic              load, advance;
    logic [BASE_W-1:0] base;
    logic [RW-1:0]     sum_q, car_q, dv_q;
    logic [NDIG-1:0]   qp_q, qn_q;

    srt_ctrl #(.LATENCY(LATENCY), .STEPS(STEPS), .BASE_W(BASE_W)) i_ctrl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start_i),
      .load_o    (load),
      .advance_o (advance),
      .busy_o    (busy),
      .base_o    (base),
      .ready_o   (ready_o)
    );

    assign ch_sum[0] = load ? x_init : sum_q;
    assign ch_car[0] = load ? '0     : car_q;
    assign ch_qp[0]  = load ? '0     : qp_q;
    assign ch_qn[0]  = load ? '0     : qn_q;
    assign dv_cur    = load ? dv_in  : dv_q;
    assign dv_act    = dv_q;

    // steps past the last digit are gated off
    for (genvar s = 0; s < STEPS; s++) begin : g_en
      assign stage_en[s] = advance && ((base + BASE_W'(s)) < BASE_W'(NDIG));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sum_q <= '0;
        car_q <= '0;
        dv_q  <= '0;
        qp_q  <= '0;
        qn_q  <= '0;
      end else if (advance) begin
        sum_q <= ch_sum[STEPS];
        car_q <= ch_car[STEPS];
        qp_q  <= ch_qp[STEPS];
        qn_q  <= ch_qn[STEPS];
        if (load) dv_q <= dv_in;
      end
    end

    assign q_pos_o     = qp_q;
    assign q_neg_o     = qn_q;
    assign rem_sum_o   = sum_q;
    assign rem_carry_o = car_q;
  end

endmodule

// File: rtl/srt_div_core_chk.sv
module srt_div_core_chk #(
  parameter int RW      = 11,
  parameter int NDIG    = 9,
  parameter int LATENCY = 9
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ready_o,
  input logic [NDIG-1:0] q_pos_o,
  input logic [NDIG-1:0] q_neg_o,
  input logic [RW-1:0]   rem_sum_o,
  input logic [RW-1:0]   rem_carry_o,
  input logic            busy,
  input logic [RW-1:0]   dv_act
);

  logic signed [RW:0] rem_abs, dv_abs;
  logic [RW-1:0]      rem_tot;

  always_comb begin
    rem_tot = rem_sum_o + rem_carry_o;
    rem_abs = rem_tot[RW-1] ? -$signed({rem_tot[RW-1], rem_tot}) : $signed({1'b0, rem_tot});
    dv_abs  = dv_act[RW-1]  ? -$signed({dv_act[RW-1], dv_act})   : $signed({1'b0, dv_act});
  end

  assert_digit_exclusive_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_pos_o & q_neg_o) == '0);

  assert_rem_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (rem_abs <= dv_abs));

  if (LATENCY > 1) begin : g_multi
    assert_ready_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_o |=> !ready_o);

    assert_ready_after_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_o |-> $past(busy));

    assert_divisor_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy |=> $stable(dv_act));
  end

  if (LATENCY > 0) begin : g_rst
    always @(posedge clk_i) begin
      if (!rst_ni) begin
        assert_reset_clear_R7: assert (!ready_o && q_pos_o == '0 && q_neg_o == '0
                                       && rem_sum_o == '0 && rem_carry_o == '0);
      end
    end
  end

endmodule

bind srt_div_core srt_div_core_chk #(.RW(RW), .NDIG(NDIG), .LATENCY(LATENCY)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ready_o     (ready_o),
  .q_pos_o     (q_pos_o),
  .q_neg_o     (q_neg_o),
  .rem_sum_o   (rem_sum_o),
  .rem_carry_o (rem_carry_o),
  .busy        (busy),
  .dv_act      (dv_act)
);

// File: tb/test_srt_div_core.sv
module srt_div_harness #(
  parameter int W     = 8,
  parameter int EXTRA = 0,
  parameter int LAT   = 9,
  parameter int CLK_P = 10
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_chk,
  output int   n_bad,
  output logic done
);

  localparam int NDIG = W + 1 + EXTRA;
  localparam int RW   = W + 3;

  typedef struct {
    longint x;
    longint d;
    int     t;
  } item_t;

  item_t q[$];
  int    cyc = 0;

  logic            start = 1'b0;
  logic [W-1:0]    dvd = '0, dvs = '0;
  logic            ready;
  logic [NDIG-1:0] q_pos, q_neg;
  logic [RW-1:0]   r_sum, r_car;

  srt_div_core #(.OP_W(W), .EXTRA_Q(EXTRA), .LATENCY(LAT)) i_srt_div_core (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .dividend_i  (dvd),
    .divisor_i   (dvs),
    .ready_o     (ready),
    .q_pos_o     (q_pos),
    .q_neg_o     (q_neg),
    .rem_sum_o   (r_sum),
    .rem_carry_o (r_car)
  );

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
  end

  initial forever @(posedge clk) cyc = cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s (W=%0d LAT=%0d): actual=%0d expected=%0d", req, W, LAT, act, exp);
    end
  endtask

  // driver: push expectation, strobe start, optionally poke while busy
  task automatic issue(input longint x, input longint d, input bit poke);
    item_t it;
    int    t0;
    it.x = x; it.d = d; it.t = cyc;
    t0 = cyc;
    q.push_back(it);
    start = 1'b1;
    dvd   = W'(x);
    dvs   = W'(d);
    @(negedge clk);
    start = 1'b0;
    if (LAT > 0) begin
      dvd = ~W'(x);   // R8: inputs change after capture
      dvs = ~W'(d);
    end
    if (poke && LAT > 1) begin
      start = 1'b1;   // R6: ignored while busy
      dvd   = W'(x + 3);
      dvs   = W'(1 << (W - 2));
      @(negedge clk);
      start = 1'b0;
    end
    while (cyc < t0 + LAT) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P / 4);
      if (rst_n && ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R6", 1, 0);
        end else begin
          item_t       it;
          longint      p, n, rr, expr, fd, efd, half;
          logic [RW-1:0] tot;
          logic signed [RW-1:0] rs;
          it   = q.pop_front();
          p    = longint'(q_pos);
          n    = longint'(q_neg);
          tot  = r_sum + r_car;
          rs   = $signed(tot);
          rr   = longint'(rs);
          expr = (it.x * (longint'(1) << NDIG)) - (p - n) * 2 * it.d;
          half = longint'(1) << (W - 2);
          chk(cyc == it.t + LAT, (LAT == 0) ? "R9" : "R5", cyc - it.t, LAT);
          chk((q_pos & q_neg) == '0, "R1", longint'(q_pos & q_neg), 0);
          chk(rr == expr, (LAT > 0) ? "R8" : "R2", rr, expr);
          chk(((rr < 0) ? -rr : rr) <= 2 * ((it.d < 0) ? -it.d : it.d), "R3", rr, 2 * it.d);
          fd = longint'(q_pos[NDIG-1]) - longint'(q_neg[NDIG-1]);
          if (it.x >= 0)         efd = (it.d < 0) ? -1 : 1;
          else if (it.x >= -half) efd = 0;
          else                    efd = (it.d < 0) ? 1 : -1;
          chk(fd == efd, "R4", fd, efd);
        end
      end
    end
  end

  initial begin
    longint mn, mx, half;
    mn   = -(longint'(1) << (W - 1));
    mx   = (longint'(1) << (W - 1)) - 1;
    half = longint'(1) << (W - 2);
    repeat (2) @(negedge clk);
    // R7: reset state
    chk(!ready, "R7", longint'(ready), 0);
    if (LAT > 0) begin
      chk(q_pos == '0 && q_neg == '0, "R7", longint'(q_pos | q_neg), 0);
      chk(r_sum == '0 && r_car == '0, "R7", longint'(r_sum | r_car), 0);
    end
    @(posedge rst_n);
    @(negedge clk);
    issue(mx, half, 1'b0);
    issue(mn, half, 1'b1);
    issue(mn, mn, 1'b0);              // most negative / -1
    issue(mx, mn, 1'b1);
    issue(0, mx, 1'b0);
    issue(0, mn, 1'b0);
    issue(-half, half, 1'b0);         // selection boundary -1/2
    issue(-half - 1, mn + half - 1, 1'b1);
    issue(half - 1, mn + half - 1, 1'b0);
    issue(-1, mx, 1'b0);
    for (int i = 0; i < 12; i++) begin
      longint v, x, dm, d;
      v  = i * 37 + 5;
      x  = ((v * 11) % (longint'(1) << W)) + mn;
      dm = (v * 7) % half;
      d  = (i % 2 == 1) ? half + dm : mn + dm;
      issue(x, d, i % 4 == 0);
    end
    repeat (LAT + 4) @(negedge clk);
    chk(q.size() == 0, "R6", q.size(), 0);
    done = 1'b1;
  end

endmodule

module test_srt_div_core;

  localparam int CLK_P = 10;

  logic clk   = 1'b0;
  logic rst_n = 1'b1;
  int   c0, c1, c2, c3, b0, b1, b2, b3;
  logic d0, d1, d2, d3;

  always #(CLK_P / 2) clk = ~clk;

  initial begin
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  end

  srt_div_harness #(.W(8),  .EXTRA(0), .LAT(9),  .CLK_P(CLK_P)) h_one   (.clk(clk), .rst_n(rst_n), .n_chk(c0), .n_bad(b0), .done(d0));
  srt_div_harness #(.W(8),  .EXTRA(2), .LAT(4),  .CLK_P(CLK_P)) h_multi (.clk(clk), .rst_n(rst_n), .n_chk(c1), .n_bad(b1), .done(d1));
  srt_div_harness #(.W(6),  .EXTRA(0), .LAT(0),  .CLK_P(CLK_P)) h_comb  (.clk(clk), .rst_n(rst_n), .n_chk(c2), .n_bad(b2), .done(d2));
  srt_div_harness #(.W(10), .EXTRA(1), .LAT(15), .CLK_P(CLK_P)) h_long  (.clk(clk), .rst_n(rst_n), .n_chk(c3), .n_bad(b3), .done(d3));

  initial begin
    int total, bad;
    bit hung;
    hung = 1'b0;
    fork
      wait (d0 && d1 && d2 && d3);
      begin
        #(CLK_P * 100000);
        hung = 1'b1;
      end
    join_any
    total = c0 + c1 + c2 + c3;
    bad   = b0 + b1 + b2 + b3;
    if (hung) begin
      total++;
      bad++;
      $display("FAIL R5 watchdog: actual=hung expected=done");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule